// File: doc/BRIEF.md
# Two-Sided Processor Mailbox

This block joins two processors, called side A and side B, through a small register window on each side. Each side owns four 32-bit outgoing slots and sees the peer's four outgoing slots as its incoming slots. Per-channel flags track whether an outgoing slot may be refilled and whether an incoming slot holds an unread word, so the two processors can pass messages without any shared lock.

Each side can also ring four doorbells on its peer. A doorbell request is a control bit that the hardware drops again once the peer's pending flag has been raised. The peer acknowledges a doorbell by writing a one to the pending bit. Every flag can be routed to the side's single interrupt line through its own enable bit.

Each side's bus is a single-cycle port. A write takes effect at the clock edge where `sel` and `we` are high. Read data is combinational from the address, and a read of an incoming slot has its side effect at the edge that ends the access. Register offsets on each side, in bytes: outgoing slot n at 4n (reads back the last word written); incoming slot n at 0x10+4n; status at 0x20; control at 0x24.

Top module: `ipc_msg_unit`

## Requirements
- R1: After reset, status reads 0x00F00000 (all send-ready flags set, nothing else) and control reads 0 on both sides, and both interrupt lines are low.
- R2: A word written to outgoing slot n (offset 4n) on one side is read from incoming slot n (offset 0x10+4n) on the other side, in both directions and for every channel.
- R3: Writing outgoing slot n clears the writer's send-ready flag, status bit 20+(3-n). A read of incoming slot n on the peer sets that flag again.
- R4: Writing outgoing slot n sets the peer's data-waiting flag, status bit 24+(3-n). A read of incoming slot n on the peer clears it.
- R5: Setting control bit 16+(3-n) on one side raises the peer's doorbell-pending flag, status bit 28+(3-n), one cycle later. The request bit then reads zero with no further write.
- R6: Writing a one to status bit 28+(3-n) clears doorbell-pending n. Writing zero leaves it set. Status writes never change the send-ready or data-waiting flags.
- R7: A side's interrupt is high exactly when some flag is set together with its enable. The doorbell, data-waiting and send-ready enables for channel n are control bits 28+(3-n), 24+(3-n) and 20+(3-n).
- R8: A write to an unmapped offset (0x28 to 0x3C, or any offset not a multiple of four) changes no register, and a read of such an offset returns zero.
- R9: Control bits 15:0 always read zero, whatever value is written to them.
- R10: When a side writes outgoing slot n in the same cycle as the peer reads incoming slot n, the write wins: afterwards send-ready n is clear and data-waiting n is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 6 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| a_irq | output | 1 | Side A interrupt |
| b_sel | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 6 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| b_irq | output | 1 | Side B interrupt |

## Verification
The embedded assertions check on every cycle that each side's send-ready flag is the complement of the peer's data-waiting flag. They also check that a doorbell request turns into a pending flag on the next cycle and is not held, and that a write-one clear removes a pending flag unless a new ring arrives. Data transport across both directions, the reversed bit order in the status and control words, interrupt gating for each source, unmapped offsets, and the write-over-read race can only be shown by the bench's directed scenarios, which check the values the ports read back.

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_sel,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam int NCH = 4;
  localparam logic [AW-1:0] OFS_RX = AW'(16);
  localparam logic [AW-1:0] OFS_SR = AW'(32);
  localparam logic [AW-1:0] OFS_CR = AW'(36);

  function automatic logic [3:0] rev4(input logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  logic [1:0]                   sel, we, wr_sr, wr_cr, irq;
  logic [1:0][AW-1:0]           addr;
  logic [1:0][DW-1:0]           wdata, rdata;
  logic [1:0][NCH-1:0]          wr_tx, rd_rx, te, rf, gip, req, gie, rie, tie, gclr;
  logic [1:0][15:0]             ctl;
  logic [1:0][NCH-1:0][DW-1:0]  slot;

  assign sel   = {b_sel, a_sel};
  assign we    = {b_we, a_we};
  assign addr  = {b_addr, a_addr};
  assign wdata = {b_wdata, a_wdata};
  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_irq = irq[0];
  assign b_irq = irq[1];

  logic unused_wbits;
  assign unused_wbits = ^{a_wdata[15:0], b_wdata[15:0]};

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      wr_sr[s] = sel[s] & we[s] & (addr[s] == OFS_SR);
      wr_cr[s] = sel[s] & we[s] & (addr[s] == OFS_CR);
      gie[s]  = rev4(ctl[s][15:12]);
      rie[s]  = rev4(ctl[s][11:8]);
      tie[s]  = rev4(ctl[s][7:4]);
      req[s]  = rev4(ctl[s][3:0]);
      gclr[s] = wr_sr[s] ? rev4(wdata[s][31:28]) : 4'b0;
      irq[s]  = |((gip[s] & gie[s]) | (rf[s] & rie[s]) | (te[s] & tie[s]));
      rdata[s] = '0;
      for (int n = 0; n < NCH; n++) begin
        wr_tx[s][n] = sel[s] & we[s] & (addr[s] == AW'(4 * n));
        rd_rx[s][n] = sel[s] & ~we[s] & (addr[s] == OFS_RX + AW'(4 * n));
        if (addr[s] == AW'(4 * n)) rdata[s] = slot[s][n];
        if (addr[s] == OFS_RX + AW'(4 * n)) rdata[s] = slot[1-s][n];
      end
      if (addr[s] == OFS_SR) rdata[s] = {rev4(gip[s]), rev4(rf[s]), rev4(te[s]), 20'b0};
      if (addr[s] == OFS_CR) rdata[s] = {ctl[s], 16'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
      te   <= '1;
      rf   <= '0;
      gip  <= '0;
      ctl  <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (wr_cr[s]) ctl[s] <= wdata[s][31:16];
        else          ctl[s][3:0] <= 4'b0;
        for (int n = 0; n < NCH; n++) begin
          if (wr_tx[s][n]) slot[s][n] <= wdata[s];
          if (wr_tx[s][n])        te[s][n] <= 1'b0;
          else if (rd_rx[1-s][n]) te[s][n] <= 1'b1;
          if (wr_tx[1-s][n])      rf[s][n] <= 1'b1;
          else if (rd_rx[s][n])   rf[s][n] <= 1'b0;
          if (req[1-s][n])        gip[s][n] <= 1'b1;
          else if (gclr[s][n])    gip[s][n] <= 1'b0;
        end
      end
    end
  end

  // R3 R4 R10
  te_rf_pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n) te[0] == ~rf[1]);
  // R3 R4 R10
  te_rf_pair_b_chk: assert property (@(posedge clk) disable iff (!rst_n) te[1] == ~rf[0]);
  // R5
  ring_a_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n) |req[0] |=> ((gip[1] & $past(req[0])) == $past(req[0])));
  // R5
  ring_b_to_a_chk: assert property (@(posedge clk) disable iff (!rst_n) |req[1] |=> ((gip[0] & $past(req[1])) == $past(req[1])));
  // R5
  req_a_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_cr[0] |=> req[0] == 4'b0);
  // R5
  req_b_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_cr[1] |=> req[1] == 4'b0);
  // R6
  w1c_a_chk: assert property (@(posedge clk) disable iff (!rst_n) (|gclr[0] && req[1] == 4'b0) |=> ((gip[0] & $past(gclr[0])) == 4'b0));
  // R6
  w1c_b_chk: assert property (@(posedge clk) disable iff (!rst_n) (|gclr[1] && req[0] == 4'b0) |=> ((gip[1] & $past(gclr[1])) == 4'b0));
endmodule

// File: tb/tb_ipc_msg_unit.sv
module tb_ipc_msg_unit;
  logic clk = 0, rst_n = 0;
  logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [5:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_irq, b_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ipc_msg_unit dut (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit s, input logic [5:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (s) begin b_sel = 1; b_we = 1; b_addr = ad; b_wdata = d; end
    else   begin a_sel = 1; a_we = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
  endtask

  task automatic rd(input bit s, input logic [5:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (s) begin b_sel = 1; b_we = 0; b_addr = ad; end
    else   begin a_sel = 1; a_we = 0; a_addr = ad; end
    #1 d = s ? b_rdata : a_rdata;
    @(negedge clk);
    a_sel = 0; b_sel = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] te_bit(int n); return 32'h1 << (20 + 3 - n); endfunction
  function automatic logic [31:0] rf_bit(int n); return 32'h1 << (24 + 3 - n); endfunction
  function automatic logic [31:0] gp_bit(int n); return 32'h1 << (28 + 3 - n); endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 2; s++) begin
      rd(s[0], 6'h20, v); check("R1 status", v, 32'h00F0_0000);
      rd(s[0], 6'h24, v); check("R1 control", v, 32'h0);
    end
    check("R1 irq", {a_irq, b_irq}, 32'h0);
  endtask

  task automatic t_transport();
    logic [31:0] v;
    for (int s = 0; s < 2; s++) begin
      for (int n = 0; n < 4; n++) begin
        logic [31:0] w;
        w = 32'hA5000000 ^ (s << 8) ^ (n * 32'h1111);
        wr(s[0], 6'(4 * n), w);
        rd(s[0], 6'h20, v); check("R3 send-ready cleared", v & te_bit(n), 32'h0);
        rd(!s[0], 6'h20, v); check("R4 data-waiting set", v & rf_bit(n), rf_bit(n));
        rd(s[0], 6'(4 * n), v); check("R2 slot readback", v, w);
        rd(!s[0], 6'(16 + 4 * n), v); check("R2 peer receives", v, w);
        rd(!s[0], 6'h20, v); check("R4 data-waiting cleared", v & rf_bit(n), 32'h0);
        rd(s[0], 6'h20, v); check("R3 send-ready restored", v, 32'h00F0_0000);
      end
    end
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    wr(0, 6'h24, 32'h1 << (16 + 3 - 2));
    idle();
    rd(1, 6'h20, v); check("R5 peer pending", v, 32'h00F0_0000 | gp_bit(2));
    rd(0, 6'h24, v); check("R5 request self-cleared", v, 32'h0);
    wr(1, 6'h20, 32'h0);
    rd(1, 6'h20, v); check("R6 write zero keeps", v, 32'h00F0_0000 | gp_bit(2));
    wr(1, 6'h20, gp_bit(2) | 32'h00F0_0000 | rf_bit(0));
    rd(1, 6'h20, v); check("R6 w1c clears only pending", v, 32'h00F0_0000);
    wr(1, 6'h24, 32'h1 << (16 + 3 - 0));
    idle();
    rd(0, 6'h20, v); check("R5 B rings A ch0", v, 32'h00F0_0000 | gp_bit(0));
    wr(0, 6'h20, gp_bit(0));
    rd(0, 6'h20, v); check("R6 w1c on A", v, 32'h00F0_0000);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 6'h24, rf_bit(1));
    idle(); check("R7 no flag no irq", b_irq, 0);
    wr(0, 6'h04, 32'h1234_5678);
    check("R7 rx irq", b_irq, 1);
    rd(1, 6'h14, v);
    check("R7 rx irq drops", b_irq, 0);
    wr(0, 6'h24, te_bit(0));
    check("R7 tx irq", a_irq, 1);
    wr(0, 6'h00, 32'h1);
    check("R7 tx irq drops", a_irq, 0);
    rd(1, 6'h10, v);
    check("R7 tx irq returns", a_irq, 1);
    wr(0, 6'h24, gp_bit(3));
    check("R7 tx enable off", a_irq, 0);
    wr(1, 6'h24, 32'h1 << 16);
    idle();
    check("R7 doorbell irq", a_irq, 1);
    wr(0, 6'h20, gp_bit(3));
    check("R7 doorbell irq cleared", a_irq, 0);
    wr(0, 6'h24, 32'h0); wr(1, 6'h24, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(0, 6'h28, 32'hFFFF_FFFF);
    wr(0, 6'h01, 32'hDEAD_BEEF);
    rd(0, 6'h28, v); check("R8 unmapped reads zero", v, 32'h0);
    rd(0, 6'h01, v); check("R8 misaligned reads zero", v, 32'h0);
    rd(0, 6'h24, v); check("R8 control untouched", v, 32'h0);
    rd(0, 6'h20, v); check("R8 status untouched", v, 32'h00F0_0000);
    rd(1, 6'h20, v); check("R8 peer status untouched", v, 32'h00F0_0000);
    wr(1, 6'h24, 32'h0000_FFFF | rf_bit(3));
    rd(1, 6'h24, v); check("R9 low control bits zero", v, rf_bit(3));
    wr(1, 6'h24, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(0, 6'h0C, 32'h1);
    @(negedge clk);
    a_sel = 1; a_we = 1; a_addr = 6'h0C; a_wdata = 32'h2;
    b_sel = 1; b_we = 0; b_addr = 6'h1C;
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0;
    rd(0, 6'h20, v); check("R10 send-ready clear", v & te_bit(3), 32'h0);
    rd(1, 6'h20, v); check("R10 data-waiting set", v & rf_bit(3), rf_bit(3));
    rd(1, 6'h1C, v); check("R10 new word", v, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_transport();
    t_doorbell();
    t_irq();
    t_unmapped();
    t_race();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule